// File: doc/BRIEF.md
# Power-Mode Controlled Rail Pins

This block drives five output pins that switch the supply rails of external peripherals on and off as the chip moves between its power-management modes. A separate power-management state machine reports the current mode on a 3-bit input: high-speed PLL run, low-speed PLL run, doze, sleep or suspend. For each pin, a configuration register selects the modes in which the pin is asserted. The same register can instead hand the pin to software, which then sets its level directly. Peripherals can therefore lose power in the same modes where internal clocks are slowed or stopped.

Each pin has its own polarity bit, so a pin can be asserted high or low. Synchronous reset puts pin 3 high and the other four pins low. The reset configuration follows the usual split: pin 0 follows both PLL run modes, pin 1 follows doze, pin 2 follows sleep, and pins 3 and 4 follow suspend. Software reaches the five registers through a simple synchronous write/read port. A read also returns the live level of the addressed pin.

Top module: `pwr_rail_ctl`

## Requirements
- R1: `pin_out` is registered. A new `pm_mode` value that is present at a rising clock edge appears on `pin_out` just after that edge, and not before it.
- R2: While `rst` is sampled high, every edge sets `pin_out` to 5'b01000 (pin 3 high, pins 0, 1, 2 and 4 low).
- R3: Reset loads the pin registers with these values: pin 0 = 8'h03, pin 1 = 8'h04, pin 2 = 8'h08, pin 3 = 8'h90, pin 4 = 8'h10. Register fields: bits 4:0 hold the mode mask (bit 0 high-speed PLL, bit 1 low-speed PLL, bit 2 doze, bit 3 sleep, bit 4 suspend), bit 5 enables the software override, bit 6 holds the override level, and bit 7 selects active-low.
- R4: `pm_mode` encodes 0 = high-speed PLL, 1 = low-speed PLL, 2 = doze, 3 = sleep, 4 = suspend. With the override off, a pin is asserted exactly when its mask bit for the current mode is set. An asserted pin drives 1 when bit 7 is 0 and drives 0 when bit 7 is 1. A pin that is not asserted drives the opposite level.
- R5: `pm_mode` values 5, 6 and 7 select no mode, so every pin without an override is deasserted.
- R6: With bit 5 set, the pin drives bit 6 as a raw level. The mode and bit 7 have no effect on it.
- R7: A write with `cfg_addr` 0 to 4 updates that pin's register at edge E. The pin reflects the new setting at edge E+1.
- R8: Writes to addresses 5, 6 and 7 are ignored: no register and no pin changes.
- R9: When `cfg_rd_en` is high at edge E, `cfg_rdata` loads the addressed register in bits 7:0 and that pin's current level in bit 8. Addresses 5 to 7 read as 0. With `cfg_rd_en` low, `cfg_rdata` holds its value.
- R10: A read and a write to the same address at the same edge return the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pm_mode | input | 3 | Current power-management mode code |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register address (pin index) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 9 | Read data: live pin level in bit 8, register in bits 7:0 |
| pin_out | output | 5 | Rail-control pin levels |

## Verification
Each result has a fixed latency. A mode change shows on the pins one edge after the new mode is present. A register write shows on the pins two edges after the strobe is driven: one edge to store the value and one to register the pin. Read data is due one edge after the strobe. The bench drives inputs on the falling edge and samples on the following falling edge, or later, counting exactly those edges. For the latency cases it also samples just before the edge to confirm the old value is still present.

// File: rtl/pwr_rail_pkg.sv
package pwr_rail_pkg;

    localparam int NUM_PINS   = 5;
    localparam int NUM_MODES  = 5;
    localparam int MODE_W     = 3;
    localparam int ADDR_W     = 3;
    localparam int CFG_W      = NUM_MODES + 3;
    localparam int RDATA_W    = CFG_W + 1;
    localparam int RAISED_PIN = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_HS_PLL  = 3'd0,
        PM_LS_PLL  = 3'd1,
        PM_DOZE    = 3'd2,
        PM_SLEEP   = 3'd3,
        PM_SUSPEND = 3'd4
    } pm_mode_e;

    // Field order is the software-visible layout, MSB first.
    typedef struct packed {
        logic                 act_low;
        logic                 sw_lvl;
        logic                 sw_ovr;
        logic [NUM_MODES-1:0] mode_mask;
    } pin_cfg_t;

    function automatic logic [NUM_MODES-1:0] mode_bit(pm_mode_e m);
        logic [NUM_MODES-1:0] b;
        b = '0;
        b[m] = 1'b1;
        return b;
    endfunction

    function automatic logic [NUM_MODES-1:0] mode_to_hot(logic [MODE_W-1:0] m);
        logic [NUM_MODES-1:0] h;
        h = '0;
        for (int k = 0; k < NUM_MODES; k++) begin
            if (m == MODE_W'(k)) h[k] = 1'b1;
        end
        return h;
    endfunction

    function automatic pin_cfg_t cfg_default(int idx);
        pin_cfg_t c;
        c = '0;
        case (idx)
            0:       c.mode_mask = mode_bit(PM_HS_PLL) | mode_bit(PM_LS_PLL);
            1:       c.mode_mask = mode_bit(PM_DOZE);
            2:       c.mode_mask = mode_bit(PM_SLEEP);
            default: c.mode_mask = mode_bit(PM_SUSPEND);
        endcase
        c.act_low = (idx == RAISED_PIN);
        return c;
    endfunction

    function automatic logic [NUM_PINS-1:0] reset_levels();
        logic [NUM_PINS-1:0] v;
        for (int k = 0; k < NUM_PINS; k++) v[k] = (k == RAISED_PIN);
        return v;
    endfunction

endpackage

// File: rtl/pwr_rail_cfg.sv
module pwr_rail_cfg
    import pwr_rail_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CFG_W-1:0]           wdata,
    output pin_cfg_t [NUM_PINS-1:0]    cfg_q
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_PINS - 1);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rst) begin
                cfg_q[i] <= cfg_default(i);
            end else if (wr_en && addr == ADDR_W'(i)) begin
                cfg_q[i] <= pin_cfg_t'(wdata);
            end
        end
    end

    // R8: a write beyond the last pin leaves every register untouched
    p_oob_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr > LAST_ADDR) |=> $stable(cfg_q));

    // R7: an in-range write lands in the register at that edge
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr <= LAST_ADDR) |=> (cfg_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/pwr_rail_drv.sv
module pwr_rail_drv
    import pwr_rail_pkg::*;
#(
    parameter int PIN_IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t             cfg,
    input  logic [NUM_MODES-1:0] mode_hot,
    output logic                 pin_q
);

    localparam logic RST_LVL = (PIN_IDX == RAISED_PIN);

    logic hit;
    logic nxt;

    always_comb begin
        hit = |(cfg.mode_mask & mode_hot);
        if (cfg.sw_ovr) nxt = cfg.sw_lvl;
        else            nxt = hit ^ cfg.act_low;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= RST_LVL;
        else     pin_q <= nxt;
    end

    // R2: reset drives the fixed level of this pin
    p_reset_level_r2: assert property (@(posedge clk)
        rst |=> (pin_q == RST_LVL));

    // R6: override wins over mode and polarity
    p_override_r6: assert property (@(posedge clk) disable iff (rst)
        cfg.sw_ovr |=> (pin_q == $past(cfg.sw_lvl)));

    // R5: with no mode selected, a pin without override rests at its idle level
    p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg.sw_ovr && mode_hot == '0) |=> (pin_q == $past(cfg.act_low)));

    // R4: an enabled mode drives the active level
    p_active_level_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg.sw_ovr && (cfg.mode_mask & mode_hot) != '0) |=> (pin_q != $past(cfg.act_low)));

endmodule

// File: rtl/pwr_rail_rdport.sv
module pwr_rail_rdport
    import pwr_rail_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  pin_cfg_t [NUM_PINS-1:0]  cfg_q,
    input  logic [NUM_PINS-1:0]      pin_q,
    output logic [RDATA_W-1:0]       rdata
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_PINS - 1);

    logic [RDATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (addr == ADDR_W'(i)) sel = {pin_q[i], cfg_q[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= sel;
    end

    // R9: reads beyond the last pin return zero
    p_oob_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > LAST_ADDR) |=> (rdata == '0));

    // R9: read data holds between reads
    p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pwr_rail_ctl.sv
module pwr_rail_ctl
    import pwr_rail_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   pm_mode,
    input  logic                cfg_wr_en,
    input  logic                cfg_rd_en,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [RDATA_W-1:0]  cfg_rdata,
    output logic [NUM_PINS-1:0] pin_out
);

    localparam logic [MODE_W-1:0]   LAST_MODE  = MODE_W'(NUM_MODES - 1);
    localparam logic [NUM_PINS-1:0] RESET_PINS = reset_levels();

    logic [NUM_MODES-1:0]    mode_hot;
    pin_cfg_t [NUM_PINS-1:0] cfg_q;

    assign mode_hot = mode_to_hot(pm_mode);

    pwr_rail_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pwr_rail_drv #(.PIN_IDX(g)) u_drv (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg_q[g]),
            .mode_hot (mode_hot),
            .pin_q    (pin_out[g])
        );
    end

    pwr_rail_rdport u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (cfg_rd_en),
        .addr  (cfg_addr),
        .cfg_q (cfg_q),
        .pin_q (pin_out),
        .rdata (cfg_rdata)
    );

    // R5: the decoded mode is never more than one mode at a time
    p_mode_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_hot));

    // R5: undefined codes select nothing
    p_mode_invalid_r5: assert property (@(posedge clk) disable iff (rst)
        (pm_mode > LAST_MODE) |-> (mode_hot == '0));

    // R2: all pins take their fixed levels under reset
    p_reset_pins_r2: assert property (@(posedge clk)
        rst |=> (pin_out == RESET_PINS));

endmodule

// File: tb/sim_pwr_rail_ctl.sv
module sim_pwr_rail_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pm_mode = 3'd0;
    logic       cfg_wr_en = 1'b0;
    logic       cfg_rd_en = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [8:0] cfg_rdata;
    logic [4:0] pin_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pwr_rail_ctl u0 (
        .clk       (clk),
        .rst       (rst),
        .pm_mode   (pm_mode),
        .cfg_wr_en (cfg_wr_en),
        .cfg_rd_en (cfg_rd_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_out   (pin_out)
    );

    // {do_write, addr, wdata, mode, expected pin_out}
    localparam int NV = 16;
    localparam logic [19:0] VECS [NV] = '{
        {1'b0, 3'd0, 8'h00, 3'd0, 5'b01001},
        {1'b0, 3'd0, 8'h00, 3'd1, 5'b01001},
        {1'b0, 3'd0, 8'h00, 3'd2, 5'b01010},
        {1'b0, 3'd0, 8'h00, 3'd3, 5'b01100},
        {1'b0, 3'd0, 8'h00, 3'd4, 5'b10000},
        {1'b0, 3'd0, 8'h00, 3'd5, 5'b01000},
        {1'b0, 3'd0, 8'h00, 3'd7, 5'b01000},
        {1'b1, 3'd0, 8'h14, 3'd4, 5'b10001},
        {1'b0, 3'd0, 8'h00, 3'd2, 5'b01011},
        {1'b1, 3'd2, 8'h88, 3'd3, 5'b01000},
        {1'b0, 3'd0, 8'h00, 3'd0, 5'b01100},
        {1'b1, 3'd4, 8'h60, 3'd0, 5'b11100},
        {1'b0, 3'd0, 8'h00, 3'd6, 5'b11100},
        {1'b1, 3'd3, 8'hBF, 3'd4, 5'b10101},
        {1'b1, 3'd5, 8'hFF, 3'd4, 5'b10101},
        {1'b1, 3'd1, 8'h1F, 3'd1, 5'b10110}
    };

    function automatic string vec_req(int i);
        if (i < 5)       return "R4";
        else if (i < 7)  return "R5";
        else if (i < 11) return "R7";
        else if (i < 14) return "R6";
        else if (i == 14) return "R8";
        else             return "R7";
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_read(logic [2:0] a);
        cfg_rd_en = 1'b1;
        cfg_addr  = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R2: reset state
        repeat (3) @(negedge clk);
        check("R2", {4'b0, pin_out}, 9'h008);
        check("R9", cfg_rdata, 9'h000);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset register contents, mode 0 active
        do_read(3'd0); check("R3", cfg_rdata, 9'h103);
        do_read(3'd1); check("R3", cfg_rdata, 9'h004);
        do_read(3'd2); check("R3", cfg_rdata, 9'h008);
        do_read(3'd3); check("R3", cfg_rdata, 9'h190);
        do_read(3'd4); check("R3", cfg_rdata, 9'h010);

        // table walk: optional write, then mode, then one edge to the pins
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][19]) do_write(VECS[i][18:16], VECS[i][15:8]);
            pm_mode = VECS[i][7:5];
            @(negedge clk);
            check(vec_req(i), {4'b0, pin_out}, {4'b0, VECS[i][4:0]});
        end

        // R7: pin lags the register write by one edge
        cfg_wr_en = 1'b1; cfg_addr = 3'd1; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check("R7", {4'b0, pin_out}, 9'h016);
        @(negedge clk);
        check("R7", {4'b0, pin_out}, 9'h014);

        // R9: readback with live level, hold, out of range
        do_read(3'd1); check("R9", cfg_rdata, 9'h000);
        do_read(3'd3); check("R9", cfg_rdata, 9'h0BF);
        do_read(3'd4); check("R9", cfg_rdata, 9'h160);
        repeat (3) @(negedge clk);
        check("R9", cfg_rdata, 9'h160);
        do_read(3'd6); check("R9", cfg_rdata, 9'h000);

        // R10: read and write to the same register at one edge
        cfg_wr_en = 1'b1; cfg_rd_en = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h03;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
        check("R10", cfg_rdata, 9'h014);
        @(negedge clk);
        do_read(3'd0); check("R10", cfg_rdata, 9'h103);
        check("R4", {4'b0, pin_out}, 9'h015);

        // R1: mode change visible only after the edge
        pm_mode = 3'd4;
        #5;
        check("R1", {4'b0, pin_out}, 9'h015);
        @(posedge clk);
        #5;
        check("R1", {4'b0, pin_out}, 9'h014);
        @(negedge clk);

        // R2 and R3: reset mid-run restores levels and defaults
        rst = 1'b1;
        @(negedge clk);
        check("R2", {4'b0, pin_out}, 9'h008);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3", {4'b0, pin_out}, 9'h010);
        do_read(3'd0); check("R3", cfg_rdata, 9'h003);
        do_read(3'd3); check("R3", cfg_rdata, 9'h090);
        do_read(3'd4); check("R3", cfg_rdata, 9'h110);

        finish_run();
    end

endmodule